// File: doc/BRIEF.md
# Periodic Interrupt and Pulse Generator

This block turns calendar carry strobes into a periodic alert for a host processor. One of four event sources is picked by a two-bit select: a 1/64-second strobe, the seconds carry, the minutes carry or the hours carry. Each picked event raises a status flag and asserts a pull-down enable that drives an external open-drain, active-low pin. The pin is released (high impedance) whenever the enable is low. Chip-enable does not gate the output. Carries caused by a 30-second adjustment reach the block as ordinary strobes, so they count as events.

In latched interrupt mode the flag and the pull-down stay asserted until the host reads the control register that holds the flag. The read produces a single-cycle clear strobe. In auto-returning pulse mode the pull-down lasts one period of the 1/128-second timebase, counted from the event, and then ends by itself. A read in pulse mode clears the flag early but leaves the pull-down running. A mask bit keeps the flag from being set and forces the pin to high impedance. The host cannot write the flag. An event that arrives while the pin is already pulled low is dropped and does not restart the pulse window.

Top module: `rtc_periodic_irq`

## Requirements
- R1: After reset, `irqFlag` is 0 and `pinPullLow` is 0.
- R2: The select `periodSel` picks the event source: 0 = `evtStrobe[0]` (1/64 s), 1 = `evtStrobe[1]` (second), 2 = `evtStrobe[2]` (minute), 3 = `evtStrobe[3]` (hour). With the pin idle and the mask off, the picked strobe sets `irqFlag` and `pinPullLow` on the next cycle. Strobes that are not picked have no effect.
- R3: With `intMode` = 1, the flag and the pull-down stay asserted until a `flagRdClr` strobe arrives. Both are 0 on the cycle after that strobe. `irqFlag` is never 1 while `pinPullLow` is 0.
- R4: With `intMode` = 0, the pull-down and the flag end on the cycle after the HOLD_TICKS-th `tick128` strobe that arrives after the event cycle. HOLD_TICKS defaults to 1.
- R5: With `intMode` = 0, a `flagRdClr` strobe clears `irqFlag` on the next cycle and leaves `pinPullLow` asserted until the window ends.
- R6: While `maskEn` = 1, both outputs are 0 from the next cycle on, and events are ignored. Clearing the mask does not revive a dropped event.
- R7: An event that arrives while `pinPullLow` = 1 changes neither output and does not restart the pulse window.
- R8: A `tick128` strobe in the same cycle as the event is not counted. `tick128` has no effect in interrupt mode.
- R9: A `flagRdClr` strobe while idle has no effect. When an event and a read arrive in the same cycle while idle, the event sets both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtStrobe | input | NUM_SRC | Single-cycle event strobes; bit 0 = 1/64 s, bit 1 = second, bit 2 = minute, bit 3 = hour |
| periodSel | input | SEL_W | Picks the event source |
| tick128 | input | 1 | Single-cycle 1/128-second timebase strobe |
| intMode | input | 1 | 1 = latched interrupt, 0 = auto-returning pulse |
| maskEn | input | 1 | 1 = flag blocked, pin released |
| flagRdClr | input | 1 | Strobe marking a completed read of the flag register |
| irqFlag | output | 1 | Status flag, read only |
| pinPullLow | output | 1 | 1 = the open-drain pin is pulled low |

## Verification
Both outputs are registered. Every effect of an event, read, mask or timebase strobe is therefore due exactly one cycle after the input is seen at a rising edge. The bench drives inputs on the falling edge and compares both outputs against a behavioural model on the following falling edge, after the rising edge that acts on them. The directed checks step one cycle per stimulus, so each expected value is read in the cycle it is due. The pulse-mode release is checked in the cycle right after the counted tick, and is also checked not to occur earlier.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  typedef struct packed {
    logic setEvt;
    logic clrFlag;
    logic releasePin;
    logic forceIdle;
  } irqStrobe_t;
endpackage

// File: rtl/rtc_irq_ctl.sv
module rtc_irq_ctl
  import rtc_irq_pkg::*;
#(
  parameter int NUM_SRC    = 4,
  parameter int HOLD_TICKS = 1,
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CNT_W = $clog2(HOLD_TICKS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtStrobe,
  input  logic [SEL_W-1:0]   periodSel,
  input  logic               tick128,
  input  logic               intMode,
  input  logic               maskEn,
  input  logic               flagRdClr,
  input  logic               pinActive,
  output irqStrobe_t         strobes
);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(HOLD_TICKS - 1);

  logic             selEvt;
  logic             windowDone;
  logic [CNT_W-1:0] tickCnt;

  // Source pick: one-hot match of the select against every source index
  always_comb begin
    selEvt = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (periodSel == SEL_W'(i)) selEvt = evtStrobe[i];
    end
  end

  // Pulse window: counts timebase strobes after the event cycle
  assign windowDone = !intMode && pinActive && tick128 && (tickCnt == LAST_TICK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (maskEn || strobes.setEvt || !pinActive || windowDone) begin
      tickCnt <= '0;
    end else if (!intMode && tick128) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.forceIdle  = maskEn;
    strobes.setEvt     = !maskEn && selEvt && !pinActive;
    strobes.clrFlag    = pinActive && (flagRdClr || windowDone);
    strobes.releasePin = pinActive && (intMode ? flagRdClr : windowDone);
  end
endmodule

// File: rtl/rtc_irq_dp.sv
module rtc_irq_dp
  import rtc_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  irqStrobe_t strobes,
  output logic       irqFlag,
  output logic       pinPullLow,
  output logic       pinActive
);
  logic flagQ;
  logic pinQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      pinQ  <= 1'b0;
    end else if (strobes.forceIdle) begin
      flagQ <= 1'b0;
      pinQ  <= 1'b0;
    end else if (strobes.setEvt) begin
      flagQ <= 1'b1;
      pinQ  <= 1'b1;
    end else begin
      if (strobes.clrFlag)    flagQ <= 1'b0;
      if (strobes.releasePin) pinQ  <= 1'b0;
    end
  end

  assign irqFlag    = flagQ;
  assign pinPullLow = pinQ;
  assign pinActive  = pinQ;
endmodule

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq
  import rtc_irq_pkg::*;
#(
  parameter int NUM_SRC    = 4,
  parameter int HOLD_TICKS = 1,
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtStrobe,
  input  logic [SEL_W-1:0]   periodSel,
  input  logic               tick128,
  input  logic               intMode,
  input  logic               maskEn,
  input  logic               flagRdClr,
  output logic               irqFlag,
  output logic               pinPullLow
);
  irqStrobe_t strobes;
  logic       pinActive;

  rtc_irq_ctl #(
    .NUM_SRC   (NUM_SRC),
    .HOLD_TICKS(HOLD_TICKS)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .evtStrobe(evtStrobe),
    .periodSel(periodSel),
    .tick128  (tick128),
    .intMode  (intMode),
    .maskEn   (maskEn),
    .flagRdClr(flagRdClr),
    .pinActive(pinActive),
    .strobes  (strobes)
  );

  rtc_irq_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .irqFlag   (irqFlag),
    .pinPullLow(pinPullLow),
    .pinActive (pinActive)
  );
endmodule

// File: rtl/rtc_periodic_irq_chk.sv
module rtc_periodic_irq_chk #(
  parameter int NUM_SRC = 4,
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] evtStrobe,
  input logic [SEL_W-1:0]   periodSel,
  input logic               tick128,
  input logic               intMode,
  input logic               maskEn,
  input logic               flagRdClr,
  input logic               irqFlag,
  input logic               pinPullLow
);
  logic pickedEvt;
  assign pickedEvt = evtStrobe[periodSel];

  // R1: outputs idle right after reset
  p_reset_idle_r1: assert property (@(posedge clk) !rstN |=> !irqFlag && !pinPullLow);

  // R2: picked event from idle raises both outputs
  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!maskEn && !pinPullLow && pickedEvt) |=> (irqFlag && pinPullLow));

  // R3: flag never stands without the pull-down
  p_flag_needs_pin_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag |-> pinPullLow);

  // R3: latched mode holds until a read
  p_int_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (intMode && pinPullLow && irqFlag && !flagRdClr && !maskEn) |=> (irqFlag && pinPullLow));

  // R5: read in pulse mode clears the flag, keeps the pin, without a tick
  p_read_keeps_pin_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!intMode && pinPullLow && flagRdClr && !tick128 && !maskEn) |=> (!irqFlag && pinPullLow));

  // R6: mask forces both outputs low
  p_mask_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    maskEn |=> (!irqFlag && !pinPullLow));

  // R4: pulse mode with no tick never releases
  p_no_early_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!intMode && pinPullLow && !tick128 && !maskEn) |=> pinPullLow);
endmodule

bind rtc_periodic_irq rtc_periodic_irq_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .evtStrobe (evtStrobe),
  .periodSel (periodSel),
  .tick128   (tick128),
  .intMode   (intMode),
  .maskEn    (maskEn),
  .flagRdClr (flagRdClr),
  .irqFlag   (irqFlag),
  .pinPullLow(pinPullLow)
);

// File: tb/tb_rtc_periodic_irq.sv
`timescale 1ns/1ps
module tb_rtc_periodic_irq;
  localparam int NSRC = 4;
  localparam int HOLD = 1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] evt = '0;
  logic [1:0] sel = '0;
  logic       tick = 1'b0;
  logic       intMode = 1'b1;
  logic       mask = 1'b0;
  logic       rd = 1'b0;
  logic       irqFlag;
  logic       pinLow;

  int    checks = 0;
  int    errors = 0;
  string phase = "R1";
  bit    finished = 0;

  always #2.5 clk = ~clk;

  rtc_periodic_irq #(.NUM_SRC(NSRC), .HOLD_TICKS(HOLD)) dut (
    .clk(clk), .rstN(rstN), .evtStrobe(evt), .periodSel(sel), .tick128(tick),
    .intMode(intMode), .maskEn(mask), .flagRdClr(rd),
    .irqFlag(irqFlag), .pinPullLow(pinLow)
  );

  // Behavioural reference
  bit mFlag = 0;
  bit mPin = 0;
  int mTicks = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mFlag = 0; mPin = 0; mTicks = 0;
    end else if (mask) begin
      mFlag = 0; mPin = 0; mTicks = 0;
    end else if (!mPin && evt[sel]) begin
      mFlag = 1; mPin = 1; mTicks = 0;
    end else if (mPin) begin
      if (intMode) begin
        if (rd) begin mFlag = 0; mPin = 0; end
      end else begin
        if (rd) mFlag = 0;
        if (tick) begin
          mTicks++;
          if (mTicks >= HOLD) begin mFlag = 0; mPin = 0; mTicks = 0; end
        end
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      checks += 2;
      if (irqFlag !== mFlag) begin
        errors++;
        $display("FAIL %s model irqFlag actual=%b expected=%b t=%0t", phase, irqFlag, mFlag, $time);
      end
      if (pinLow !== mPin) begin
        errors++;
        $display("FAIL %s model pinPullLow actual=%b expected=%b t=%0t", phase, pinLow, mPin, $time);
      end
    end
  end

  task automatic expectOut(input bit f, input bit p, input string req);
    checks++;
    if (irqFlag !== f || pinLow !== p) begin
      errors++;
      $display("FAIL %s flag/pin actual=%b%b expected=%b%b t=%0t", req, irqFlag, pinLow, f, p, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic fire(input int idx);
    evt[idx] = 1'b1; cyc(); evt = '0;
  endtask

  task automatic doRead();
    rd = 1'b1; cyc(); rd = 1'b0;
  endtask

  task automatic doTick();
    tick = 1'b1; cyc(); tick = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    expectOut(0, 0, "R1");
    rstN = 1'b1;
    cyc();
    expectOut(0, 0, "R1");

    // R2: source select, latched mode
    phase = "R2";
    intMode = 1'b1;
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      for (int o = 0; o < 4; o++) begin
        if (o != s) begin fire(o); expectOut(0, 0, "R2"); end
      end
      fire(s);
      expectOut(1, 1, "R2");
      doRead();
      expectOut(0, 0, "R3");
    end

    // R3: hold until read; R8: tick ignored in latched mode
    phase = "R3";
    sel = 2'd1;
    fire(1);
    idle(20);
    expectOut(1, 1, "R3");
    doTick();
    expectOut(1, 1, "R8");
    doRead();
    expectOut(0, 0, "R3");

    // R4: pulse mode auto release
    phase = "R4";
    intMode = 1'b0;
    sel = 2'd0;
    fire(0);
    expectOut(1, 1, "R4");
    idle(5);
    expectOut(1, 1, "R4");
    doTick();
    expectOut(0, 0, "R4");

    // R5: read clears flag only
    phase = "R5";
    fire(0);
    doRead();
    expectOut(0, 1, "R5");
    idle(3);
    expectOut(0, 1, "R5");
    doTick();
    expectOut(0, 0, "R5");

    // R7: event during pulse ignored, window not restarted
    phase = "R7";
    fire(0);
    idle(2);
    fire(0);
    expectOut(1, 1, "R7");
    doTick();
    expectOut(0, 0, "R7");
    fire(0);
    doRead();
    fire(0);
    expectOut(0, 1, "R7");
    doTick();
    expectOut(0, 0, "R7");

    // R8: tick in the event cycle not counted
    phase = "R8";
    evt[0] = 1'b1; tick = 1'b1; cyc(); evt = '0; tick = 1'b0;
    expectOut(1, 1, "R8");
    idle(2);
    expectOut(1, 1, "R8");
    doTick();
    expectOut(0, 0, "R8");

    // R6: mask in both modes
    phase = "R6";
    intMode = 1'b1;
    fire(0);
    expectOut(1, 1, "R6");
    mask = 1'b1; cyc();
    expectOut(0, 0, "R6");
    fire(0);
    expectOut(0, 0, "R6");
    mask = 1'b0; cyc();
    expectOut(0, 0, "R6");
    intMode = 1'b0;
    fire(0);
    mask = 1'b1; cyc();
    expectOut(0, 0, "R6");
    mask = 1'b0; idle(2);
    expectOut(0, 0, "R6");

    // R9: read while idle, event plus read together
    phase = "R9";
    intMode = 1'b1;
    doRead();
    expectOut(0, 0, "R9");
    evt[0] = 1'b1; rd = 1'b1; cyc(); evt = '0; rd = 1'b0;
    expectOut(1, 1, "R9");
    doRead();
    expectOut(0, 0, "R9");

    // Mixed stimulus against the model
    phase = "R2 R3 R4 R5 R6 R7";
    for (int i = 0; i < 4000; i++) begin
      evt     = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'd0;
      tick    = ($urandom_range(0, 5) == 0);
      rd      = ($urandom_range(0, 9) == 0);
      mask    = ($urandom_range(0, 29) == 0);
      if ($urandom_range(0, 99) == 0) intMode = ~intMode;
      if ($urandom_range(0, 149) == 0) sel = 2'($urandom_range(0, 3));
      cyc();
    end
    evt = '0; tick = 1'b0; rd = 1'b0; mask = 1'b0;
    idle(2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule